// File: doc/BRIEF.md
# PTP Clock Rate Servo

This block closes the loop between the timestamp differences measured in each precision-time exchange and the frequency of an adjustable local clock. For every exchange it takes two signed numbers: the master-to-slave difference (Sync receive time minus Sync send time) and the slave-to-master difference (Delay_Resp time minus Delay_Req send time). A single strobe marks both numbers as valid.

Each difference is smoothed by its own first-order recursive low-pass filter. The one-way path delay and the offset from the master are worked out from the two filtered values. A proportional-integral controller then acts on the offset. Its result is negated, limited, and driven out as a signed rate correction in parts per billion, with a one-cycle update pulse. Only fixed-point arithmetic is used. The filter coefficient and both gains are static inputs that software sets up.

A synchronous clear input restarts the loop, for example after a step of the local clock or a change of master.

Top module: `ptp_rate_servo`

## Requirements
- R1: Each filter updates on an accepted sample as y = floor((c*y_prev + (65536-c)*x) / 65536), where c is the 16-bit unsigned coefficient `filt_coef` (a Q0.16 fraction).
- R2: On the first accepted sample after reset or clear, a filter loads the input value directly, whatever c is.
- R3: The one-way delay is floor((Fm+Fs)/2), and the offset error is Fm minus that delay, where Fm and Fs are the filtered master-to-slave and slave-to-master values.
- R4: The integrator adds the offset error on each accepted sample. The controller sum is floor(Gp*err/256) + floor(Gi*acc/256), where Gp (`gain_p`) and Gi (`gain_i`) are unsigned Q8.8 values and acc is the integrator after the update.
- R5: The integrator saturates to the range -2^31 to 2^31-1 and does not wrap.
- R6: `rate_ppb` carries the negated controller sum, so a positive offset (slave ahead) gives a negative rate command.
- R7: `rate_ppb` is limited to the range -500000 to +500000.
- R8: `rate_vld` is high for exactly one cycle, three cycles after the cycle in which `smp_vld` was sampled high. It is never high at any other time.
- R9: `rate_ppb` holds its value between update pulses.
- R10: A high `clr` zeroes both filter states, the integrator and `rate_ppb`, and cancels updates already in flight. A sample presented in the same cycle as `clr` is ignored.
- R11: After reset, `rate_ppb` is 0 and `rate_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous loop restart |
| smp_vld | input | 1 | Exchange differences valid |
| m2s_dly | input | 32 | Signed master-to-slave difference |
| s2m_dly | input | 32 | Signed slave-to-master difference |
| filt_coef | input | 16 | Filter coefficient, Q0.16 |
| gain_p | input | 16 | Proportional gain, Q8.8 |
| gain_i | input | 16 | Integral gain, Q8.8 |
| rate_ppb | output | 32 | Signed rate correction in ppb |
| rate_vld | output | 1 | Update pulse for rate_ppb |

## Verification
The bench sweeps the filter coefficient from 0 to 65535 with several gain pairs and compares every update against an arithmetic model. A design that rounded in place of flooring, or that did not preload the filter on the first sample, would be off by small amounts or by whole input values. It drives the integrator into its positive and negative limits and then unwinds it. An accumulator that wrapped would give a wrong sign or a wrong size when it came back into range. It also drives large offsets, to check that the output limit is applied after the negation. It asserts clear on its own and together with a sample, to check that in-flight pulses are cancelled and that the next sample is preloaded again.

// File: rtl/ptp_servo_pkg.sv
package ptp_servo_pkg;
  localparam int DEF_DLY_W   = 32;
  localparam int DEF_COEF_W  = 16;
  localparam int DEF_GAIN_W  = 16;
  localparam int DEF_GAIN_FR = 8;
  localparam int DEF_ACC_W   = 32;
  localparam int DEF_RATE_W  = 32;
  localparam int DEF_LIMIT   = 500000;

  function automatic logic signed [63:0] clamp64(input logic signed [63:0] v,
                                                 input logic signed [63:0] lo,
                                                 input logic signed [63:0] hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/servo_iir.sv
module servo_iir #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic        [CW-1:0] coef,
  output logic signed [DW-1:0] y
);
  logic          primed;
  logic   [CW:0] one_m;
  logic signed [63:0] mix;

  always_comb begin
    one_m = {1'b1, {CW{1'b0}}} - {1'b0, coef};
    mix   = $signed({1'b0, coef}) * y + $signed({1'b0, one_m}) * x;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      y      <= '0;
      primed <= 1'b0;
    end else if (en) begin
      primed <= 1'b1;
      if (!primed) y <= x;
      else         y <= mix[CW +: DW];
    end
  end
endmodule

// File: rtl/servo_pi.sv
module servo_pi #(
  parameter int EW  = 33,
  parameter int GW  = 16,
  parameter int GF  = 8,
  parameter int AW  = 32,
  parameter int OW  = 32,
  parameter int LIM = 500000
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [EW-1:0] err,
  input  logic        [GW-1:0] gp,
  input  logic        [GW-1:0] gi,
  output logic signed [OW-1:0] rate,
  output logic                 rate_vld
);
  import ptp_servo_pkg::*;
  localparam logic signed [63:0] ACC_HI = (64'sd1 <<< (AW-1)) - 64'sd1;
  localparam logic signed [63:0] ACC_LO = -(64'sd1 <<< (AW-1));
  localparam logic signed [63:0] OUT_HI = 64'(LIM);
  localparam logic signed [63:0] OUT_LO = -64'(LIM);

  logic signed [AW-1:0] acc;
  logic signed [63:0]   acc_sum, acc_nx, p_term, i_term, total;

  always_comb begin
    acc_sum = acc + err;
    acc_nx  = clamp64(acc_sum, ACC_LO, ACC_HI);
    p_term  = ($signed({1'b0, gp}) * err) >>> GF;
    i_term  = ($signed({1'b0, gi}) * acc_nx) >>> GF;
    total   = clamp64(-(p_term + i_term), OUT_LO, OUT_HI);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      acc      <= '0;
      rate     <= '0;
      rate_vld <= 1'b0;
    end else begin
      rate_vld <= en;
      if (en) begin
        acc  <= AW'(acc_nx);
        rate <= OW'(total);
      end
    end
  end
endmodule

// File: rtl/ptp_rate_servo.sv
module ptp_rate_servo #(
  parameter int DLY_W   = ptp_servo_pkg::DEF_DLY_W,
  parameter int COEF_W  = ptp_servo_pkg::DEF_COEF_W,
  parameter int GAIN_W  = ptp_servo_pkg::DEF_GAIN_W,
  parameter int GAIN_FR = ptp_servo_pkg::DEF_GAIN_FR,
  parameter int ACC_W   = ptp_servo_pkg::DEF_ACC_W,
  parameter int RATE_W  = ptp_servo_pkg::DEF_RATE_W,
  parameter int LIMIT   = ptp_servo_pkg::DEF_LIMIT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     smp_vld,
  input  logic signed [DLY_W-1:0]  m2s_dly,
  input  logic signed [DLY_W-1:0]  s2m_dly,
  input  logic        [COEF_W-1:0] filt_coef,
  input  logic        [GAIN_W-1:0] gain_p,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [RATE_W-1:0] rate_ppb,
  output logic                     rate_vld
);
  localparam int EW = DLY_W + 1;

  logic                    wipe, take;
  logic signed [DLY_W-1:0] fm, fs;
  logic                    v1, v2;
  logic signed [EW-1:0]    dsum, dhalf, derr, err_q;

  assign wipe = rst | clr;
  assign take = smp_vld & ~clr;

  servo_iir #(.DW(DLY_W), .CW(COEF_W)) u_filt_m (
    .clk(clk), .clr(wipe), .en(take), .x(m2s_dly), .coef(filt_coef), .y(fm));
  servo_iir #(.DW(DLY_W), .CW(COEF_W)) u_filt_s (
    .clk(clk), .clr(wipe), .en(take), .x(s2m_dly), .coef(filt_coef), .y(fs));

  always_comb begin
    dsum  = EW'(fm) + EW'(fs);
    dhalf = dsum >>> 1;
    derr  = EW'(fm) - dhalf;
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      v1    <= 1'b0;
      v2    <= 1'b0;
      err_q <= '0;
    end else begin
      v1 <= take;
      v2 <= v1;
      if (v1) err_q <= derr;
    end
  end

  servo_pi #(.EW(EW), .GW(GAIN_W), .GF(GAIN_FR), .AW(ACC_W), .OW(RATE_W), .LIM(LIMIT)) u_pi (
    .clk(clk), .clr(wipe), .en(v2), .err(err_q), .gp(gain_p), .gi(gain_i),
    .rate(rate_ppb), .rate_vld(rate_vld));
endmodule

// File: rtl/ptp_rate_servo_chk.sv
module ptp_rate_servo_chk #(
  parameter int RATE_W = 32,
  parameter int LIMIT  = 500000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clr,
  input logic                     smp_vld,
  input logic signed [RATE_W-1:0] rate_ppb,
  input logic                     rate_vld
);
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    rate_vld |-> $past(smp_vld, 3) && !$past(clr, 3));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rate_vld |=> !rate_vld || $past(smp_vld, 3));

  a_r7_rate_bound: assert property (@(posedge clk) disable iff (rst)
    (rate_ppb <= LIMIT) && (rate_ppb >= -LIMIT));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!rate_vld && !$past(clr)) |-> $stable(rate_ppb));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rate_ppb == 0) && !rate_vld);
endmodule

bind ptp_rate_servo ptp_rate_servo_chk #(.RATE_W(RATE_W), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld),
  .rate_ppb(rate_ppb), .rate_vld(rate_vld));

// File: tb/ptp_rate_servo_test.sv
`timescale 1ns/1ps
module ptp_rate_servo_test;
  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, smp_vld = 1'b0;
  logic signed [31:0] m2s_dly = '0, s2m_dly = '0;
  logic [15:0] filt_coef = '0, gain_p = '0, gain_i = '0;
  logic signed [31:0] rate_ppb;
  logic rate_vld;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  longint fm, fs, acc, last_rate;
  bit primed;
  longint seed = 64'h1234_5678;

  ptp_rate_servo uut (.clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld),
    .m2s_dly(m2s_dly), .s2m_dly(s2m_dly), .filt_coef(filt_coef),
    .gain_p(gain_p), .gain_i(gain_i), .rate_ppb(rate_ppb), .rate_vld(rate_vld));

  always #4 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint nextr();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic model_clear();
    fm = 0; fs = 0; acc = 0; primed = 0; last_rate = 0;
  endtask

  // model of R1..R7
  task automatic model_step(longint m, longint s);
    longint c, d, e, pt, it;
    c = longint'(filt_coef);
    if (!primed) begin fm = m; fs = s; end
    else begin
      fm = (c * fm + (65536 - c) * m) >>> 16;
      fs = (c * fs + (65536 - c) * s) >>> 16;
    end
    primed = 1;
    d = (fm + fs) >>> 1;
    e = fm - d;
    acc = clampl(acc + e, -(64'sd1 <<< 31), (64'sd1 <<< 31) - 1);
    pt = (longint'(gain_p) * e) >>> 8;
    it = (longint'(gain_i) * acc) >>> 8;
    last_rate = clampl(-(pt + it), -500000, 500000);
  endtask

  task automatic send(longint m, longint s, string req);
    @(negedge clk);
    m2s_dly = 32'(m); s2m_dly = 32'(s); smp_vld = 1'b1;
    model_step(m, s);
    @(negedge clk); smp_vld = 1'b0;
    check("R8 early pulse", rate_vld, 0);
    @(negedge clk);
    check("R8 early pulse", rate_vld, 0);
    @(negedge clk);
    check("R8 pulse", rate_vld, 1);
    check(req, rate_ppb, last_rate);
    @(negedge clk);
    check("R8 pulse width", rate_vld, 0);
    check("R9 hold", rate_ppb, last_rate);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
    check("R10 clear rate", rate_ppb, 0);
    check("R10 clear vld", rate_vld, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int coefs[5] = '{0, 16384, 32768, 49152, 65535};
    int gps[3]   = '{256, 0, 384};
    int gis[3]   = '{0, 256, 32};
    model_clear();
    repeat (3) @(negedge clk);
    check("R11 reset rate", rate_ppb, 0);
    check("R11 reset vld", rate_vld, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after reset", rate_ppb, 0);

    // R1 R2 R3 R4 R6: coefficient and gain sweep
    for (int ci = 0; ci < 5; ci++) begin
      for (int gk = 0; gk < 3; gk++) begin
        filt_coef = 16'(coefs[ci]); gain_p = 16'(gps[gk]); gain_i = 16'(gis[gk]);
        do_clear();
        // first sample is loaded directly (R2)
        send(5000 + (nextr() % 300), 3000 + (nextr() % 300), "R2 first load");
        for (int k = 0; k < 7; k++)
          send(4000 + (nextr() % 900), 3500 + (nextr() % 900), "R1 R3 R4 R6 filter/offset/PI");
      end
    end

    // R5: integrator saturation and unwind
    filt_coef = 16'd0; gain_p = 16'd0; gain_i = 16'd1;
    do_clear();
    for (int k = 0; k < 3; k++) send(64'sd1 <<< 30, -(64'sd1 <<< 30), "R5 positive limit");
    gain_i = 16'd256;
    send(-(64'sd1 <<< 30), 64'sd1 <<< 30, "R5 unwind");
    send(-(64'sd1 <<< 30), 64'sd1 <<< 30, "R5 unwind to small");
    check("R5 unwound value", rate_ppb, 1);
    for (int k = 0; k < 3; k++) send(-(64'sd1 <<< 30), 64'sd1 <<< 30, "R5 negative limit");
    send(64'sd1 <<< 30, -(64'sd1 <<< 30), "R5 negative unwind");
    send(64'sd1 <<< 30, -(64'sd1 <<< 30), "R5 negative unwind to small");
    check("R5 negative unwound value", rate_ppb, 0);

    // R7: output limit in both directions
    gain_p = 16'hFFFF; gain_i = 16'd0;
    do_clear();
    send(100000, -100000, "R7 negative limit");
    check("R7 negative limit value", rate_ppb, -500000);
    send(-100000, 100000, "R7 positive limit");
    check("R7 positive limit value", rate_ppb, 500000);

    // R10: clear together with a sample
    gain_p = 16'd256; gain_i = 16'd64; filt_coef = 16'd40000;
    send(9000, 1000, "R10 pre-clear state");
    @(negedge clk); clr = 1'b1; smp_vld = 1'b1; m2s_dly = 32'sd77777; s2m_dly = 32'sd0;
    @(negedge clk); clr = 1'b0; smp_vld = 1'b0;
    model_clear();
    for (int k = 0; k < 4; k++) begin
      check("R10 no pulse from cleared sample", rate_vld, 0);
      check("R10 rate zero", rate_ppb, 0);
      @(negedge clk);
    end
    send(2000, 600, "R10 R2 reload after clear");
    // clear cancels an in-flight update
    @(negedge clk); smp_vld = 1'b1; m2s_dly = 32'sd3000; s2m_dly = 32'sd100;
    @(negedge clk); smp_vld = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
    for (int k = 0; k < 3; k++) begin
      check("R10 in-flight cancelled", rate_vld, 0);
      @(negedge clk);
    end
    send(1500, 1500, "R10 R2 fresh after cancel");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule